// File: doc/BRIEF.md
# Multiplier-Free Stereo-to-Mono Linear Upsampler

This block takes a stream of 16-bit signed stereo PCM sample pairs at the base audio rate and turns it into a 24-bit mono stream at a rate that is two, four or eight times higher. The two channels are first averaged into one mono value. Straight-line interpolation then fills the gap between each pair of consecutive mono values with evenly spaced points. The ratio is a power of two, so the spacing between points comes from an arithmetic right shift of the difference, and the points themselves come from repeated additions. The datapath contains no multiplier.

Each input pair produces a group of output samples. The group starts at the previous mono value and steps towards the new one. The mono value fills the upper 16 bits of each 24-bit output. The lower 8 bits hold the interpolation fraction. The input side and the output side each use a valid/ready handshake. Downstream back-pressure can hold the block for as long as it needs. The block accepts a new pair in the same cycle that the last output of the current group is taken, so a downstream that is always ready sees one output on every cycle.

Top module: `pcm_lerp_upsampler`

## Requirements
- R1: While reset is active, and directly after it, `out_valid` is 0 and `in_ready` is 1.
- R2: The mono value of a pair is floor((left + right) / 2), computed with a 17-bit sum so that it cannot overflow. For example, left = 32767 and right = -32768 give -1.
- R3: The first output of the group that a pair starts is the mono value of the pair accepted before it, shifted left by 8 bits.
- R4: Output k of a group (k = 0 .. N-1) equals prev*256 + k*((cur-prev)*256/N). Here prev and cur are the previous and the new mono values and N is the ratio. The value is exact, with no rounding.
- R5: `osr_sel` encodes the ratio: 0 selects 2, 1 selects 4, and 2 or 3 select 8. Each accepted pair yields exactly N outputs.
- R6: `in_ready` is 1 only when no output of the group is pending, or when the last pending output is being taken in that same cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_sample` and `out_valid` hold their values into the next cycle.
- R8: After reset the previous mono value is 0, so the first group ramps up from 0.
- R9: `osr_sel` is sampled only in the cycle a pair is accepted. Changing it while a group is in progress does not change that group.
- R10: `out_valid` is 1 exactly while outputs of the accepted group remain pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Stereo pair offered |
| in_ready | output | 1 | Block accepts the offered pair |
| in_left | input | 16 | Left channel sample, signed |
| in_right | input | 16 | Right channel sample, signed |
| osr_sel | input | 2 | Ratio select: 0 = x2, 1 = x4, 2 or 3 = x8 |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample |
| out_sample | output | 24 | Interpolated mono sample, signed |

## Verification
The assertions assume that `in_left`, `in_right` and `osr_sel` are stable and known on every edge where `in_valid` and `in_ready` are both 1. They also assume that `out_ready` is never X once reset has been released. The bench drives every input at the falling edge from a fixed-seed random source, so all inputs are settled and defined long before the rising edge that samples them. The random phase changes `osr_sel` on every cycle and toggles both `in_valid` and `out_ready`. This puts mid-group ratio changes and stalls on either side within the same legal input space.

// File: rtl/lerp_pkg.sv
package lerp_pkg;

   // Ratio select code to right-shift amount (log2 of the ratio), clamped at max_shift.
   function automatic int sel_to_shift(input int sel, input int max_shift);
      int s;
      s = sel + 1;
      if (s > max_shift) s = max_shift;
      return s;
   endfunction

   // Index of the last output in a group for a given shift.
   function automatic int shift_to_last(input int shift);
      return (1 << shift) - 1;
   endfunction

endpackage

// File: rtl/lerp_mixer.sv
module lerp_mixer #(
   parameter int IN_W = 16
) (
   input  logic signed [IN_W-1:0] left_i,
   input  logic signed [IN_W-1:0] right_i,
   output logic signed [IN_W-1:0] mono_o
);
   localparam int SUM_W = IN_W + 1;

   logic signed [SUM_W-1:0] sum;

   // one guard bit keeps the sum exact; arithmetic shift halves with floor
   always_comb begin
      sum    = SUM_W'(left_i) + SUM_W'(right_i);
      mono_o = IN_W'(sum >>> 1);
   end
endmodule

// File: rtl/lerp_step_gen.sv
module lerp_step_gen #(
   parameter int IN_W      = 16,
   parameter int FRAC      = 8,
   parameter int MAX_SHIFT = 3,
   parameter int SH_W      = 2,
   parameter int STEP_W    = IN_W + 1 + FRAC
) (
   input  logic signed [IN_W-1:0]   cur_i,
   input  logic signed [IN_W-1:0]   prev_i,
   input  logic        [SH_W-1:0]   shift_i,
   output logic signed [STEP_W-1:0] step_o
);
   localparam int DIFF_W = IN_W + 1;
   localparam int NCAND  = MAX_SHIFT + 1;

   logic signed [DIFF_W-1:0] diff;
   logic signed [STEP_W-1:0] wide;
   logic signed [STEP_W-1:0] cand [NCAND];

   always_comb begin
      diff = DIFF_W'(cur_i) - DIFF_W'(prev_i);
      wide = STEP_W'(diff) <<< FRAC;
   end

   // one shifted copy per legal ratio; exact because FRAC >= MAX_SHIFT
   for (genvar g = 0; g < NCAND; g++) begin : g_cand
      assign cand[g] = wide >>> g;
   end

   always_comb begin
      step_o = cand[0];
      for (int i = 1; i < NCAND; i++) begin
         if (int'(shift_i) == i) step_o = cand[i];
      end
   end
endmodule

// File: rtl/lerp_ramp.sv
module lerp_ramp #(
   parameter int OUT_W  = 24,
   parameter int STEP_W = 25,
   parameter int CNT_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic signed [OUT_W-1:0]  base_i,
   input  logic signed [STEP_W-1:0] step_i,
   input  logic        [CNT_W-1:0]  last_i,
   input  logic                     take_i,
   output logic signed [OUT_W-1:0]  acc_o,
   output logic                     busy_o,
   output logic                     at_last_o
);
   logic signed [OUT_W-1:0]  acc_q;
   logic signed [STEP_W-1:0] step_q;
   logic        [CNT_W-1:0]  cnt_q;
   logic        [CNT_W-1:0]  last_q;
   logic                     busy_q;
   logic signed [STEP_W-1:0] sum;

   always_comb begin
      at_last_o = busy_q && (cnt_q == last_q);
      sum       = STEP_W'(acc_q) + step_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         step_q <= '0;
         cnt_q  <= '0;
         last_q <= '0;
         busy_q <= 1'b0;
      end else if (load_i) begin
         acc_q  <= base_i;
         step_q <= step_i;
         cnt_q  <= '0;
         last_q <= last_i;
         busy_q <= 1'b1;
      end else if (take_i && busy_q) begin
         if (cnt_q == last_q) begin
            busy_q <= 1'b0;
         end else begin
            acc_q <= OUT_W'(sum);
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign acc_o  = acc_q;
   assign busy_o = busy_q;
endmodule

// File: rtl/pcm_lerp_upsampler.sv
module pcm_lerp_upsampler #(
   parameter int IN_W      = 16,
   parameter int OUT_W     = 24,
   parameter int MAX_SHIFT = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic signed [IN_W-1:0]  in_left,
   input  logic signed [IN_W-1:0]  in_right,
   input  logic [$clog2(MAX_SHIFT+1)-1:0] osr_sel,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic signed [OUT_W-1:0] out_sample
);
   import lerp_pkg::*;

   localparam int FRAC   = OUT_W - IN_W;
   localparam int STEP_W = IN_W + 1 + FRAC;
   localparam int SH_W   = $clog2(MAX_SHIFT + 1);
   localparam int CNT_W  = MAX_SHIFT;

   if (MAX_SHIFT < 1) begin : g_bad_shift
      $error("MAX_SHIFT must be at least 1");
   end
   if (FRAC < MAX_SHIFT) begin : g_bad_frac
      $error("OUT_W - IN_W must cover MAX_SHIFT fraction bits");
   end
   if (IN_W < 2) begin : g_bad_in
      $error("IN_W must be at least 2");
   end

   logic signed [IN_W-1:0]   mono;
   logic signed [IN_W-1:0]   prev_q;
   logic        [SH_W-1:0]   shift_n;
   logic        [CNT_W-1:0]  last_n;
   logic signed [STEP_W-1:0] step;
   logic signed [OUT_W-1:0]  base;
   logic                     busy;
   logic                     at_last;
   logic                     in_fire;
   logic                     out_fire;

   lerp_mixer #(.IN_W(IN_W)) mix_i (
      .left_i (in_left),
      .right_i(in_right),
      .mono_o (mono)
   );

   always_comb begin
      shift_n = SH_W'(sel_to_shift(int'(osr_sel), MAX_SHIFT));
      last_n  = CNT_W'(shift_to_last(int'(shift_n)));
      base    = {prev_q, {FRAC{1'b0}}};
   end

   lerp_step_gen #(
      .IN_W(IN_W), .FRAC(FRAC), .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W), .STEP_W(STEP_W)
   ) step_i (
      .cur_i  (mono),
      .prev_i (prev_q),
      .shift_i(shift_n),
      .step_o (step)
   );

   always_comb begin
      out_fire = busy && out_ready;
      in_ready = !busy || (out_ready && at_last);
      in_fire  = in_valid && in_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else if (in_fire) prev_q <= mono;
   end

   lerp_ramp #(.OUT_W(OUT_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) ramp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (in_fire),
      .base_i   (base),
      .step_i   (step),
      .last_i   (last_n),
      .take_i   (out_fire),
      .acc_o    (out_sample),
      .busy_o   (busy),
      .at_last_o(at_last)
   );

   assign out_valid = busy;
endmodule

// File: rtl/lerp_checker.sv
module lerp_checker #(
   parameter int IN_W      = 16,
   parameter int OUT_W     = 24,
   parameter int MAX_SHIFT = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic signed [IN_W-1:0]  in_left,
   input logic signed [IN_W-1:0]  in_right,
   input logic [$clog2(MAX_SHIFT+1)-1:0] osr_sel,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic signed [OUT_W-1:0] out_sample
);
   localparam int FRAC  = OUT_W - IN_W;
   localparam int REM_W = MAX_SHIFT + 1;

   logic [REM_W-1:0]        remaining;
   logic signed [IN_W-1:0]  prev_m;
   logic signed [OUT_W-1:0] exp_first;
   logic signed [IN_W:0]    pair_sum;
   int                      sh;

   always_comb begin
      pair_sum = (IN_W+1)'(in_left) + (IN_W+1)'(in_right);
      sh = int'(osr_sel) + 1;
      if (sh > MAX_SHIFT) sh = MAX_SHIFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining <= '0;
         prev_m    <= '0;
         exp_first <= '0;
      end else begin
         if (in_valid && in_ready) begin
            remaining <= REM_W'(1 << sh);
            prev_m    <= IN_W'(pair_sum >>> 1);
            exp_first <= {prev_m, {FRAC{1'b0}}};
         end else if (out_valid && out_ready && remaining != 0) begin
            remaining <= remaining - 1'b1;
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (!out_valid && in_ready)
            else $error("reset state wrong");
      end
   end

   assert_ready_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == (remaining == 0 || (out_ready && remaining == 1)));

   assert_valid_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (remaining != 0));

   assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

   assert_group_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_sample == exp_first));
endmodule

bind pcm_lerp_upsampler lerp_checker #(
   .IN_W(IN_W), .OUT_W(OUT_W), .MAX_SHIFT(MAX_SHIFT)
) chk_i (.*);

// File: tb/pcm_lerp_upsampler_tb.sv
module pcm_lerp_upsampler_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int IN_W  = 16;
   localparam int OUT_W = 24;
   localparam int FRAC  = OUT_W - IN_W;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic in_valid = 1'b0;
   logic in_ready;
   logic signed [IN_W-1:0] in_left = '0;
   logic signed [IN_W-1:0] in_right = '0;
   logic [1:0] osr_sel = 2'd2;
   logic out_valid;
   logic out_ready = 1'b0;
   logic signed [OUT_W-1:0] out_sample;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   int prev_mono = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_lerp_upsampler dut_i (.*);

   function automatic int mix_of(int l, int r);
      return (l + r) >>> 1;
   endfunction

   function automatic int ratio_of(int sel);
      return (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // model of one accepted pair: queue the whole group
   task automatic model_accept(input int l, input int r, input int sel);
      int m, n, st;
      m  = mix_of(l, r);
      n  = ratio_of(sel);
      st = ((m - prev_mono) * (1 << FRAC)) / n;
      for (int k = 0; k < n; k++) exp_q.push_back(prev_mono * (1 << FRAC) + k * st);
      prev_mono = m;
   endtask

   task automatic settle_and_check(output bit in_acc);
      bit hs_out;
      int pend;
      #1;
      pend   = exp_q.size();
      hs_out = out_valid && out_ready;
      check(out_valid == (pend != 0), "R10", int'(out_valid), int'(pend != 0));
      check(in_ready == (pend == 0 || (out_ready && pend == 1)), "R6",
            int'(in_ready), int'(pend == 0 || (out_ready && pend == 1)));
      if (hs_out && pend != 0) begin
         check(int'(out_sample) == exp_q[0], "R4", int'(out_sample), exp_q[0]);
         void'(exp_q.pop_front());
      end
      in_acc = in_valid && in_ready;
      if (in_acc) model_accept(int'(in_left), int'(in_right), int'(osr_sel));
   endtask

   initial begin
      bit acc;
      bit hold;
      int hold_val;
      int dl[6] = '{1000, 32767, -32768, 32767, 100, 0};
      int dr[6] = '{1000, 32767, -32768, -32768, -50, 0};
      int ds[6] = '{2, 3, 2, 1, 0, 0};
      void'($urandom(1234));
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check(!out_valid && in_ready, "R1", int'({out_valid, in_ready}), 1);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(!out_valid && in_ready, "R1", int'({out_valid, in_ready}), 1);

      // directed corners, downstream always ready; first group ramps from 0 (R8)
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         in_valid = 1'b1; out_ready = 1'b1;
         in_left = IN_W'(dl[i]); in_right = IN_W'(dr[i]); osr_sel = 2'(ds[i]);
         acc = 0;
         while (!acc) begin
            settle_and_check(acc);
            if (!acc) begin
               @(negedge clk);
               osr_sel = 2'($urandom_range(0, 3));
            end
         end
         if (i == 0) check(exp_q[0] == 0 && int'(out_sample) >= 0, "R8", exp_q[0], 0);
      end
      // mix of opposite full-scale values floors to -1 (R2)
      check(mix_of(32767, -32768) == -1, "R2", mix_of(32767, -32768), -1);

      // random phase: random valid, random back-pressure, osr_sel changing every cycle (R9, R5)
      hold = 0;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if (hold) check(out_valid && int'(out_sample) == hold_val, "R7", int'(out_sample), hold_val);
         if (!in_valid || acc) begin
            in_valid = ($urandom_range(0, 9) < 8);
            in_left  = IN_W'($urandom);
            in_right = IN_W'($urandom);
         end
         osr_sel   = 2'($urandom_range(0, 3));
         out_ready = ($urandom_range(0, 9) < 6);
         settle_and_check(acc);
         hold     = out_valid && !out_ready;
         hold_val = int'(out_sample);
      end

      // drain: every accepted pair produced exactly its count (R5)
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      for (int c = 0; c < 20; c++) begin
         settle_and_check(acc);
         @(negedge clk);
      end
      #1;
      check(exp_q.size() == 0 && !out_valid, "R5", exp_q.size(), 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule